// File: doc/BRIEF.md
# NOR Flash Buffered Program Sequencer

This block programs a short run of consecutive 16-bit words into a parallel NOR flash by way of the device's on-chip write buffer. It replaces one full command sequence per word with a single command sequence for the whole run. A request carries a start word address and a word count. The words themselves arrive on a valid/ready stream.

The block produces a fixed series of asynchronous bus writes:
- the two-step unlock;
- the buffer-load command and the count field, both at the start address;
- one write per data word at rising addresses;
- a confirm command sent to the address of the last word loaded.

When the confirm write has finished on the bus, the block pulses a trigger for the status poller. A count that is zero or larger than the buffer is refused at once with an error pulse.

Each bus write has a fixed shape. Chip enable goes low together with a stable address and data. Write enable goes low after a setup time, stays low for a pulse time, and is then released. Chip enable stays low for one further hold cycle. An idle cycle separates each write from the next.

Top module: `nor_wbuf_prog`

## Requirements
- R1: After reset the bus is idle: nor_ce_n and nor_we_n are 1, and busy, done, start_poll, err and s_ready are 0.
- R2: An accepted request begins with two writes: data 0x00AA at address 0x555, then data 0x0055 at address 0x2AA.
- R3: The third write places the command 0x0025 at the start address.
- R4: The fourth write places the word count minus one at the start address (for example, a count of 32 gives 0x001F).
- R5: Data words are written in stream order, one write per accepted word, at start address plus 0, 1, 2 and so on.
- R6: The last write of a request places the command 0x0029 at the address of the last data word loaded, which is start address plus count minus one.
- R7: A start with a count of 0 or a count above MAX_WORDS (32) gives a one-clock err pulse, produces no bus write, and leaves busy at 0.
- R8: s_ready is 1 only in the data phase while no bus write is in progress. While s_valid stays low the sequence waits and issues no write.
- R9: In every write, nor_ce_n is low for T_SETUP+T_PULSE+1 cycles and nor_we_n is low for exactly T_PULSE cycles inside that window. Address and data hold steady while nor_ce_n is low.
- R10: A request produces exactly count+5 writes. done and start_poll rise together for one clock, in the cycle after the confirm write releases chip enable.
- R11: start is ignored while busy is 1. A start present in the same cycle as done is accepted, so a new request begins with no extra gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a buffered program |
| start_addr | input | ADDR_W | First word address of the run |
| word_count | input | CNT_W | Number of words to program (1 to MAX_WORDS) |
| s_valid | input | 1 | Data stream word valid |
| s_data | input | 16 | Data stream word |
| s_ready | output | 1 | Block accepts a stream word this cycle |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock pulse when the confirm write has completed |
| start_poll | output | 1 | One-clock trigger for the status poller, coincident with done |
| err | output | 1 | One-clock pulse for a refused count |
| nor_ce_n | output | 1 | Flash chip enable, active low |
| nor_we_n | output | 1 | Flash write enable, active low |
| nor_addr | output | ADDR_W | Flash word address |
| nor_dq | output | 16 | Flash write data |

## Verification
The end of one request and the acceptance of the next can occur in the same clock. In the cycle where done is high, the controller is already idle and samples start. To provoke this, the bench holds start high with fixed parameters for a whole request. That same run also shows that start is ignored while busy. The bench then checks that busy is 1 on the clock after done, and that the second series of writes matches a fresh request exactly, unlock pair included.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

  localparam int DQ_W = 16;

  localparam logic [31:0] UNLK_A_ADDR = 32'h0000_0555;
  localparam logic [31:0] UNLK_B_ADDR = 32'h0000_02AA;
  localparam logic [DQ_W-1:0] UNLK_A_DATA = 16'h00AA;
  localparam logic [DQ_W-1:0] UNLK_B_DATA = 16'h0055;
  localparam logic [DQ_W-1:0] CMD_BUF_LOAD = 16'h0025;
  localparam logic [DQ_W-1:0] CMD_CONFIRM = 16'h0029;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLK_A,
    ST_UNLK_B,
    ST_LOAD_CMD,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_FINISH
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // a count is legal when it is between one and the buffer size
  function automatic bit count_legal(input int n, input int max_words);
    return (n >= 1) && (n <= max_words);
  endfunction

  // the device takes the count as n-1
  function automatic logic [DQ_W-1:0] count_field(input int n);
    return DQ_W'(n - 1);
  endfunction

  // word address of the k-th data word of a run
  function automatic int load_addr(input int base, input int k);
    return base + k;
  endfunction

endpackage

// File: rtl/nwb_bus_writer.sv
module nwb_bus_writer
  import nwb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_data,
  output logic              busy,
  output logic              ack,
  output logic              ce_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DQ_W-1:0]   dq
);

  localparam int TM_MAX = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int TM_W   = $clog2(TM_MAX + 1);

  phase_e            ph_q;
  logic [TM_W-1:0]   tmr_q;

  assign busy = (ph_q != PH_IDLE);
  assign ack  = (ph_q == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      tmr_q <= '0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      addr  <= '0;
      dq    <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (req) begin
            ph_q  <= PH_SETUP;
            tmr_q <= TM_W'(T_SETUP - 1);
            ce_n  <= 1'b0;
            addr  <= req_addr;
            dq    <= req_data;
          end
        end
        PH_SETUP: begin
          if (tmr_q == '0) begin
            ph_q  <= PH_STROBE;
            tmr_q <= TM_W'(T_PULSE - 1);
            we_n  <= 1'b0;
          end else begin
            tmr_q <= tmr_q - TM_W'(1);
          end
        end
        PH_STROBE: begin
          if (tmr_q == '0) begin
            ph_q <= PH_HOLD;
            we_n <= 1'b1;
          end else begin
            tmr_q <= tmr_q - TM_W'(1);
          end
        end
        PH_HOLD: begin
          ph_q <= PH_IDLE;
          ce_n <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nwb_step_ctrl.sv
module nwb_step_ctrl
  import nwb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_WORDS = 32,
  parameter int CNT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              s_valid,
  input  logic [DQ_W-1:0]   s_data,
  output logic              s_ready,
  input  logic              wr_busy,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DQ_W-1:0]   wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  step_e             step_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] last_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  idx_q;
  logic              active;
  logic              last_word;

  assign active    = (step_q != ST_IDLE) && (step_q != ST_FINISH);
  assign busy      = (step_q != ST_IDLE);
  assign s_ready   = (step_q == ST_DATA) && !wr_busy;
  assign wr_req    = active && !wr_busy && ((step_q != ST_DATA) || s_valid);
  assign last_word = (idx_q == cnt_q - CNT_W'(1));

  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    unique case (step_q)
      ST_UNLK_A:   begin wr_addr = ADDR_W'(UNLK_A_ADDR); wr_data = UNLK_A_DATA; end
      ST_UNLK_B:   begin wr_addr = ADDR_W'(UNLK_B_ADDR); wr_data = UNLK_B_DATA; end
      ST_LOAD_CMD: begin wr_addr = base_q; wr_data = CMD_BUF_LOAD; end
      ST_COUNT:    begin wr_addr = base_q; wr_data = count_field(int'(cnt_q)); end
      ST_DATA:     begin
        wr_addr = ADDR_W'(load_addr(int'(base_q), int'(idx_q)));
        wr_data = s_data;
      end
      ST_CONFIRM:  begin wr_addr = last_q; wr_data = CMD_CONFIRM; end
      default:     begin wr_addr = '0; wr_data = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      base_q <= '0;
      last_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (step_q)
        ST_IDLE: begin
          if (start) begin
            if (count_legal(int'(word_count), MAX_WORDS)) begin
              base_q <= start_addr;
              cnt_q  <= word_count;
              idx_q  <= '0;
              step_q <= ST_UNLK_A;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_UNLK_A:   if (wr_req) step_q <= ST_UNLK_B;
        ST_UNLK_B:   if (wr_req) step_q <= ST_LOAD_CMD;
        ST_LOAD_CMD: if (wr_req) step_q <= ST_COUNT;
        ST_COUNT:    if (wr_req) step_q <= ST_DATA;
        ST_DATA: begin
          if (wr_req) begin
            last_q <= wr_addr;
            idx_q  <= idx_q + CNT_W'(1);
            if (last_word) step_q <= ST_CONFIRM;
          end
        end
        ST_CONFIRM:  if (wr_req) step_q <= ST_FINISH;
        ST_FINISH: begin
          if (wr_ack) begin
            step_q <= ST_IDLE;
            done   <= 1'b1;
          end
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nor_wbuf_prog.sv
module nor_wbuf_prog
  import nwb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_WORDS = 32,
  parameter int T_SETUP   = 2,
  parameter int T_PULSE   = 3,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              s_valid,
  input  logic [15:0]       s_data,
  output logic              s_ready,
  output logic              busy,
  output logic              done,
  output logic              start_poll,
  output logic              err,
  output logic              nor_ce_n,
  output logic              nor_we_n,
  output logic [ADDR_W-1:0] nor_addr,
  output logic [15:0]       nor_dq
);

  // internal events, named for the checker
  logic              wr_req;
  logic              wr_ack;
  logic              wr_busy;
  logic [ADDR_W-1:0] wr_addr;
  logic [DQ_W-1:0]   wr_data;
  logic              done_evt;

  nwb_step_ctrl #(
    .ADDR_W   (ADDR_W),
    .MAX_WORDS(MAX_WORDS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_addr(start_addr),
    .word_count(word_count),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .wr_busy   (wr_busy),
    .wr_ack    (wr_ack),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .done      (done_evt),
    .err       (err)
  );

  nwb_bus_writer #(
    .ADDR_W (ADDR_W),
    .T_SETUP(T_SETUP),
    .T_PULSE(T_PULSE)
  ) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (wr_req),
    .req_addr(wr_addr),
    .req_data(wr_data),
    .busy    (wr_busy),
    .ack     (wr_ack),
    .ce_n    (nor_ce_n),
    .we_n    (nor_we_n),
    .addr    (nor_addr),
    .dq      (nor_dq)
  );

  assign done       = done_evt;
  assign start_poll = done_evt;

endmodule

// File: rtl/nor_wbuf_prog_chk.sv
module nor_wbuf_prog_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              s_ready,
  input logic              nor_ce_n,
  input logic              nor_we_n,
  input logic [ADDR_W-1:0] nor_addr,
  input logic [15:0]       nor_dq,
  input logic              wr_req,
  input logic              wr_ack,
  input logic              wr_busy
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nor_ce_n && nor_we_n));

  p_we_in_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !nor_we_n |-> !nor_ce_n);

  p_bus_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nor_ce_n && !$past(nor_ce_n)) |-> ($stable(nor_addr) && $stable(nor_dq)));

  p_ready_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && !wr_busy && nor_ce_n));

  p_one_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_ack));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && nor_ce_n));

endmodule

bind nor_wbuf_prog nor_wbuf_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .s_ready (s_ready),
  .nor_ce_n(nor_ce_n),
  .nor_we_n(nor_we_n),
  .nor_addr(nor_addr),
  .nor_dq  (nor_dq),
  .wr_req  (wr_req),
  .wr_ack  (wr_ack),
  .wr_busy (wr_busy)
);

// File: tb/nor_wbuf_prog_tb.sv
module nor_wbuf_prog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int MAX_WORDS  = 32;
  localparam int T_SETUP    = 2;
  localparam int T_PULSE    = 3;
  localparam int CNT_W      = 6;
  localparam int NV         = 4;
  localparam int LOG_N      = 1024;

  localparam logic [15:0] VB [NV] = '{16'h0100, 16'h1234, 16'h0FF0, 16'h2000};
  localparam int          VC [NV] = '{4, 1, 7, 32};
  localparam int          VG [NV] = '{0, 2, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0] word_count = '0;
  logic s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic s_ready, busy, done, start_poll, err, nor_ce_n, nor_we_n;
  logic [ADDR_W-1:0] nor_addr;
  logic [15:0] nor_dq;

  int n_chk = 0;
  int n_fail = 0;
  int n_wr = 0;
  int n_done = 0;
  int n_poll = 0;
  int n_errp = 0;
  int tm_bad = 0;
  int ce_run = 0;
  int we_run = 0;
  logic prev_ce = 1'b1;
  logic prev_we = 1'b1;
  logic [ADDR_W-1:0] log_a [LOG_N];
  logic [15:0] log_d [LOG_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_wbuf_prog #(
    .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .busy(busy), .done(done), .start_poll(start_poll), .err(err),
    .nor_ce_n(nor_ce_n), .nor_we_n(nor_we_n), .nor_addr(nor_addr), .nor_dq(nor_dq)
  );

  // bus monitor: logs each write when write enable is released
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nor_ce_n) ce_run++;
      if (!nor_we_n) we_run++;
      if (!prev_we && nor_we_n) begin
        if (n_wr < LOG_N) begin
          log_a[n_wr] = nor_addr;
          log_d[n_wr] = nor_dq;
        end
        if (we_run != T_PULSE) tm_bad++;
        we_run = 0;
        n_wr++;
      end
      if (!prev_ce && nor_ce_n) begin
        if (ce_run != T_SETUP + T_PULSE + 1) tm_bad++;
        ce_run = 0;
      end
      if (done) n_done++;
      if (start_poll) n_poll++;
      if (err) n_errp++;
      prev_we = nor_we_n;
      prev_ce = nor_ce_n;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dgen(input logic [15:0] base, input int i);
    return base ^ (16'(i) * 16'h0123) ^ 16'hA5C3;
  endfunction

  // issue (optionally), feed the stream, wait for done, check the write log
  task automatic run_seq(input logic [15:0] base, input int cnt, input int gap,
                         input bit issue, input bit hold, input bit poke);
    int w0, d0, p0, t0, k;
    bit rdy;
    w0 = n_wr; d0 = n_done; p0 = n_poll; t0 = tm_bad;
    if (issue) begin
      tick();
      start = 1'b1; start_addr = base; word_count = CNT_W'(cnt);
      tick();
      if (!hold) start = 1'b0;
    end
    for (int i = 0; i < cnt; i++) begin
      if (poke && i == 1) begin
        // R11: a new start while busy must not disturb the run
        start = 1'b1; start_addr = 16'h7777; word_count = CNT_W'(2);
        tick();
        start = 1'b0;
      end
      for (int g = 0; g < gap; g++) tick();
      s_valid = 1'b1;
      s_data = dgen(base, i);
      do begin
        rdy = s_ready;
        tick();
      end while (!rdy);
      s_valid = 1'b0;
    end
    k = 0;
    while (n_done == d0 && k < 3000) begin tick(); k++; end
    chk(n_done == d0 + 1, "R10", "done pulse seen", n_done - d0, 1);
    chk(n_poll == p0 + 1, "R10", "start_poll pulse seen", n_poll - p0, 1);
    chk(done && start_poll, "R10", "done with start_poll", int'(start_poll), 1);
    chk(n_wr - w0 == cnt + 5, "R10", "write count", n_wr - w0, cnt + 5);
    chk(log_a[w0] == 16'h0555 && log_d[w0] == 16'h00AA, "R2", "unlock A",
        int'(log_a[w0]), 16'h0555);
    chk(log_a[w0+1] == 16'h02AA && log_d[w0+1] == 16'h0055, "R2", "unlock B",
        int'(log_a[w0+1]), 16'h02AA);
    chk(log_a[w0+2] == base && log_d[w0+2] == 16'h0025, "R3", "load command",
        int'(log_d[w0+2]), 16'h0025);
    chk(log_a[w0+3] == base && log_d[w0+3] == 16'(cnt - 1), "R4", "count field",
        int'(log_d[w0+3]), cnt - 1);
    for (int i = 0; i < cnt; i++) begin
      chk(log_a[w0+4+i] == base + 16'(i) && log_d[w0+4+i] == dgen(base, i), "R5",
          "data word", int'(log_d[w0+4+i]), int'(dgen(base, i)));
    end
    chk(log_a[w0+4+cnt] == base + 16'(cnt - 1) && log_d[w0+4+cnt] == 16'h0029, "R6",
        "confirm address", int'(log_a[w0+4+cnt]), int'(base + 16'(cnt - 1)));
    chk(tm_bad == t0, "R9", "strobe timing faults", tm_bad - t0, 0);
    tick();
    chk(!done && !start_poll, "R10", "pulse width one clock", int'(done), 0);
  endtask

  task automatic reject(input int cnt);
    int e0, w0, noisy;
    e0 = n_errp; w0 = n_wr; noisy = 0;
    tick();
    start = 1'b1; start_addr = 16'h0500; word_count = CNT_W'(cnt);
    tick();
    start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (!nor_ce_n || busy || s_ready) noisy++;
      tick();
    end
    chk(n_errp == e0 + 1, "R7", "err pulse count", n_errp - e0, 1);
    chk(noisy == 0 && n_wr == w0, "R7", "no bus activity", noisy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(nor_ce_n && nor_we_n && !busy && !done && !start_poll && !err && !s_ready,
        "R1", "idle outputs in reset", int'({nor_ce_n, nor_we_n, busy}), 3'b110);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(nor_ce_n && !busy && !s_ready, "R1", "idle after reset", int'(busy), 0);

    // table-driven runs (R2..R6, R8 gaps, R9, R10)
    for (int v = 0; v < NV; v++) begin
      run_seq(VB[v], VC[v], VG[v], 1'b1, 1'b0, 1'b0);
    end

    // R8: stalled stream produces no writes
    begin
      int w0, hi;
      tick();
      start = 1'b1; start_addr = 16'h3000; word_count = CNT_W'(2);
      tick();
      start = 1'b0;
      repeat (60) tick();
      w0 = n_wr; hi = 0;
      repeat (20) begin
        if (!nor_ce_n) hi++;
        tick();
      end
      chk(w0 == 4 + n_wr - n_wr + (w0 - 4) && hi == 0 && s_ready, "R8",
          "stall holds with ready high", hi, 0);
      chk(n_wr == w0, "R8", "no write during stall", n_wr - w0, 0);
      for (int i = 0; i < 2; i++) begin
        bit rdy;
        s_valid = 1'b1; s_data = dgen(16'h3000, i);
        do begin rdy = s_ready; tick(); end while (!rdy);
        s_valid = 1'b0;
      end
      repeat (40) tick();
      chk(log_a[n_wr-1] == 16'h3001 && log_d[n_wr-1] == 16'h0029, "R6",
          "confirm after stall", int'(log_a[n_wr-1]), 16'h3001);
    end

    // R7: refused counts
    reject(0);
    reject(33);

    // R11: start while busy is ignored
    run_seq(16'h0400, 5, 1, 1'b1, 1'b0, 1'b1);

    // R11: start held through done is accepted back to back
    run_seq(16'h0600, 3, 0, 1'b1, 1'b1, 1'b0);
    chk(busy == 1'b1, "R11", "accepted in done cycle", int'(busy), 1);
    start = 1'b0;
    run_seq(16'h0600, 3, 1, 1'b0, 1'b0, 1'b0);

    repeat (5) tick();
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

endmodule